// File: doc/BRIEF.md
# FSK cycle classifier and run-length bitizer

This block turns a stream of 8-bit samples from a peak-detected low-frequency receiver into a stream of half-bit symbols. Each accepted sample is compared against a fixed level to get one bit. The block then measures the number of samples between successive rising edges of that bit. Each measured cycle is sorted into one of two subcarrier tones: a short cycle (divide-by-8 tone, symbol 1) or a long cycle (divide-by-10 tone, symbol 0).

Consecutive cycles of the same tone form a run. When the tone changes, the run that just ended is rounded to a number of half-bit periods, using a different divisor per tone. That number of copies of the run's symbol is then sent out. The extra short-tone cycle that a transmitter inserts between nibbles disappears in the rounding, so it needs no special handling.

Both sides are valid/ready streams:
- A sample transfers on a clock edge where `s_valid` and `s_ready` are both high.
- A symbol transfers on a clock edge where `m_valid` and `m_ready` are both high.
- Once raised, `m_valid` and `m_data` hold until the symbol is taken.
- While any symbol of a burst is still waiting, `s_ready` stays low, so the input is stalled until the burst has fully drained.

Top module: `fsk_cycle_bitizer`

## Requirements
- R1: A sample value below 127 slices to 0; any value of 127 or more slices to 1.
- R2: A cycle spans the samples from one 0-to-1 transition of the sliced bit to the next. Measurement starts at the first such transition. The bit before the first sample after reset counts as 1, so the first sample can never be a transition.
- R3: A cycle of 8 samples or fewer is the short tone (symbol 1); a longer cycle is the long tone (symbol 0). The interval counter saturates, so an interval longer than 256 samples still counts as long.
- R4: When a cycle's tone differs from the current run, the ended run of n cycles is converted to a half-bit count: (n+1)/6 for a short-tone run and (n+1)/5 for a long-tone run, using integer division. The new run then starts with n = 1.
- R5: A half-bit count of 0 or 1 emits one symbol; 2, 3 or 4 emit that many symbols; 5 or more emit none.
- R6: Every emitted symbol equals the tone of the run that ended (1 short, 0 long). The run still in progress emits nothing until a tone change ends it.
- R7: The run-length counter saturates at 255 cycles, so a run of more than 255 cycles behaves as a run of 255 and cannot wrap.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` keeps its value on the next cycle.
- R9: While any symbol is pending, `s_ready` is low and no sample is accepted; a burst is loaded only when nothing is pending.
- R10: After reset `m_valid` is 0, `s_ready` is 1 and no run or cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Block accepts a sample (low while symbols are pending) |
| s_data | input | 8 | Unsigned sample value |
| m_valid | output | 1 | Half-bit symbol available |
| m_ready | input | 1 | Consumer takes the symbol |
| m_data | output | 1 | Half-bit symbol: 1 short tone, 0 long tone |

## Verification
The slicer is driven with samples sitting exactly at 127 and 126, and with scattered values on either side. This shows whether the compare level is off by one. Cycle lengths of 7 through 11 are mixed inside runs, which separates the 8/9 classification boundary from the rounding. Run lengths are swept from 1 to 29 cycles for each tone, between neighbours of the other tone. This covers every rounding step and the point where bursts stop being emitted.

Further patterns target specific faults:
- A leading high sample, which exposes a wrong initial value of the previous bit.
- A 260-sample interval, which shows whether the interval counter wraps.
- A 260-cycle run, which shows whether the run counter wraps.

Ready is held high in some runs and driven from a pseudo-random pattern in others. This exercises the input stall and the output hold under back-pressure.

// File: rtl/fsk_bitizer_pkg.sv
package fsk_bitizer_pkg;

  localparam int SYM_MAX = 4;
  localparam int SYM_CW  = $clog2(SYM_MAX + 1);

  typedef logic [SYM_CW-1:0] sym_cnt_t;

  typedef struct packed {
    logic valid;  // a complete cycle was measured on this sample
    logic fast;   // 1: short (divide-by-8) tone, 0: long tone
  } cyc_evt_t;

  // half-bit count -> number of symbols to send
  function automatic sym_cnt_t burst_len(input int unsigned hb);
    if (hb <= 1)
      return sym_cnt_t'(1);
    else if (hb <= SYM_MAX)
      return sym_cnt_t'(hb);
    else
      return '0;
  endfunction

endpackage

// File: rtl/fsk_interval_meter.sv
module fsk_interval_meter
  import fsk_bitizer_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int SLICE_LVL = 127,
  parameter int FAST_MAX  = 8,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic [SMP_W-1:0] smp_data,
  output cyc_evt_t         cyc
);

  localparam logic [GAP_W-1:0] GAP_TOP = '1;

  logic             prev_bit;
  logic             synced;
  logic [GAP_W-1:0] gap;
  logic             bit_now;
  logic             rise;
  logic [GAP_W:0]   span;

  assign bit_now   = (smp_data >= SMP_W'(SLICE_LVL));
  assign rise      = smp_en & bit_now & ~prev_bit;
  assign span      = {1'b0, gap} + (GAP_W+1)'(1);
  assign cyc.valid = rise & synced;
  assign cyc.fast  = (span <= (GAP_W+1)'(FAST_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit <= 1'b1;
      synced   <= 1'b0;
      gap      <= '0;
    end else if (smp_en) begin
      prev_bit <= bit_now;
      if (rise) begin
        synced <= 1'b1;
        gap    <= '0;
      end else if (gap != GAP_TOP) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_GAP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !rise && gap == GAP_TOP) |=> (gap == GAP_TOP)); // R3

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (synced && gap == '0)); // R2

endmodule

// File: rtl/fsk_run_tracker.sv
module fsk_run_tracker
  import fsk_bitizer_pkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cyc_evt_t cyc,
  output logic     emit_valid,
  output logic     emit_val,
  output sym_cnt_t emit_cnt
);

  localparam logic [RUN_W-1:0] RUN_TOP = '1;

  logic             have_run;
  logic             run_val;
  logic [RUN_W-1:0] run_len;
  logic             change;
  logic             same;
  logic [RUN_W:0]   ext;
  logic [RUN_W:0]   hb;

  assign same   = cyc.valid & have_run & (cyc.fast == run_val);
  assign change = cyc.valid & have_run & (cyc.fast != run_val);
  assign ext    = {1'b0, run_len} + (RUN_W+1)'(1);
  assign hb     = run_val ? (ext / (RUN_W+1)'(6)) : (ext / (RUN_W+1)'(5));

  always_comb begin
    emit_cnt   = burst_len(32'(hb));
    emit_val   = run_val;
    emit_valid = change & (emit_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_run <= 1'b0;
      run_val  <= 1'b0;
      run_len  <= '0;
    end else if (cyc.valid) begin
      if (!have_run || change) begin
        have_run <= 1'b1;
        run_val  <= cyc.fast;
        run_len  <= RUN_W'(1);
      end else if (run_len != RUN_TOP) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  AST_RUN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (same && run_len == RUN_TOP) |=> (run_len == RUN_TOP)); // R7

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> (run_len == RUN_W'(1) && run_val == $past(cyc.fast))); // R4

endmodule

// File: rtl/fsk_symbol_emitter.sv
module fsk_symbol_emitter
  import fsk_bitizer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     load_val,
  input  sym_cnt_t load_cnt,
  output logic     m_valid,
  input  logic     m_ready,
  output logic     m_data,
  output logic     busy
);

  sym_cnt_t pend;
  logic     pend_val;

  assign busy    = (pend != '0);
  assign m_valid = busy;
  assign m_data  = pend_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_val <= 1'b0;
    end else if (load) begin
      pend     <= load_cnt;
      pend_val <= load_val;
    end else if (m_valid && m_ready) begin
      pend <= pend - 1'b1;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (pend == '0)); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R8

  AST_PEND_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= sym_cnt_t'(SYM_MAX)); // R5

endmodule

// File: rtl/fsk_cycle_bitizer.sv
module fsk_cycle_bitizer
  import fsk_bitizer_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int SLICE_LVL = 127,
  parameter int FAST_MAX  = 8,
  parameter int GAP_W     = 8,
  parameter int RUN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_data
);

  cyc_evt_t cyc;
  logic     accept;
  logic     busy;
  logic     emit_valid;
  logic     emit_val;
  sym_cnt_t emit_cnt;

  assign s_ready = ~busy;
  assign accept  = s_valid & s_ready;

  fsk_interval_meter #(
    .SMP_W(SMP_W), .SLICE_LVL(SLICE_LVL), .FAST_MAX(FAST_MAX), .GAP_W(GAP_W)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .smp_en(accept), .smp_data(s_data), .cyc(cyc)
  );

  fsk_run_tracker #(.RUN_W(RUN_W)) u_runs (
    .clk(clk), .rst_n(rst_n), .cyc(cyc),
    .emit_valid(emit_valid), .emit_val(emit_val), .emit_cnt(emit_cnt)
  );

  fsk_symbol_emitter u_emit (
    .clk(clk), .rst_n(rst_n),
    .load(emit_valid), .load_val(emit_val), .load_cnt(emit_cnt),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .busy(busy)
  );

  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |=> (!s_ready && m_valid)); // R9

endmodule

// File: tb/fsk_cycle_bitizer_bench.sv
module fsk_cycle_bitizer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       m_valid;
  logic       m_ready = 1'b0;
  logic       m_data;

  always #10 clk = ~clk;

  fsk_cycle_bitizer u_fsk_cycle_bitizer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc_q[$];
  bit exp_q[$];
  bit got_q[$];
  int stall_bad;
  int hold_bad;
  bit hold_arm;
  bit hold_val;
  int bp_mode;
  bit bnd;
  int k_val = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] hi_v();
    k_val++;
    if (bnd) return 8'd127;
    return 8'(127 + (k_val * 37) % 129);
  endfunction

  function automatic logic [7:0] lo_v();
    k_val++;
    if (bnd) return 8'd126;
    return 8'((k_val * 53) % 127);
  endfunction

  // reference: tones, runs, rounding, burst sizes
  function automatic void build_expect();
    bit have;
    bit rv;
    int rl;
    have = 0; rv = 0; rl = 0;
    exp_q.delete();
    foreach (cyc_q[i]) begin
      bit f;
      int hb;
      int k;
      f = (cyc_q[i] <= 8);
      if (!have) begin
        have = 1; rv = f; rl = 1;
      end else if (f == rv) begin
        if (rl < 255) rl++;
      end else begin
        hb = rv ? (rl + 1) / 6 : (rl + 1) / 5;
        k = (hb <= 1) ? 1 : (hb <= 4) ? hb : 0;
        for (int j = 0; j < k; j++) exp_q.push_back(rv);
        rv = f; rl = 1;
      end
    end
  endfunction

  // outputs observed at the falling edge; handshakes happen at the next rise
  task automatic observe();
    if (bp_mode == 0) m_ready = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = (bp_mode == 1) ? (lfsr[0] | lfsr[3]) : lfsr[0];
    end
    if (hold_arm && (!m_valid || m_data != hold_val)) hold_bad++;
    hold_arm = m_valid && !m_ready;
    hold_val = m_data;
    if (m_valid && m_ready) got_q.push_back(m_data);
    if (m_valid && s_ready) stall_bad++;
  endtask

  task automatic put_sample(input logic [7:0] v);
    bit done;
    done = 0;
    while (!done) begin
      @(negedge clk);
      s_data = v;
      s_valid = 1'b1;
      observe();
      done = s_ready;
      @(posedge clk);
    end
  endtask

  task automatic drain();
    int idle;
    idle = 0;
    while (idle < 6) begin
      @(negedge clk);
      s_valid = 1'b0;
      observe();
      if (m_valid) idle = 0; else idle++;
      @(posedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input string tag, input bit lead_hi);
    do_reset();
    got_q.delete();
    stall_bad = 0; hold_bad = 0; hold_arm = 0;
    if (lead_hi) begin
      put_sample(hi_v());
      repeat (3) put_sample(lo_v());
    end else begin
      put_sample(lo_v());
    end
    foreach (cyc_q[i]) begin
      put_sample(hi_v());
      for (int j = 1; j < cyc_q[i]; j++) put_sample(lo_v());
    end
    put_sample(hi_v());
    drain();
    build_expect();
    check(got_q.size() == exp_q.size(), tag, "symbol count",
          got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], tag, $sformatf("symbol %0d", i),
            int'(got_q[i]), int'(exp_q[i]));
    check(stall_bad == 0, "R9", "input accepted while symbols pending", stall_bad, 0);
    check(hold_bad == 0, "R8", "output changed while stalled", hold_bad, 0);
  endtask

  task automatic add(input int len, input int cnt);
    for (int i = 0; i < cnt; i++) cyc_q.push_back(len);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    // R10: idle after reset
    do_reset();
    @(negedge clk);
    check(m_valid == 1'b0, "R10", "m_valid after reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R10", "s_ready after reset", int'(s_ready), 1);

    // R1: samples exactly at 127 / 126
    bnd = 1; bp_mode = 0;
    cyc_q.delete();
    add(8, 6); add(10, 5); add(8, 12); add(10, 1);
    run_case("R1", 0);
    bnd = 0;

    // R2: a leading high sample is not an edge
    bp_mode = 1;
    cyc_q.delete();
    add(10, 5); add(8, 6); add(10, 10); add(8, 1);
    run_case("R2", 1);

    // R3: 8/9 boundary with noisy lengths
    bp_mode = 2;
    cyc_q.delete();
    add(8, 6); add(9, 5); add(7, 6); add(11, 5); add(8, 3); add(9, 2); add(8, 1);
    run_case("R3", 0);

    // R4 / R5 / R6: run-length sweep for both tones
    for (int n = 1; n <= 29; n++) begin
      bp_mode = n % 3;
      cyc_q.delete();
      add(10, 5);
      for (int i = 0; i < n; i++) cyc_q.push_back((i % 3 == 1) ? 7 : 8);
      add(11, 5); add(8, 1);
      run_case("R4", 0);
      cyc_q.delete();
      add(8, 6);
      for (int i = 0; i < n; i++) cyc_q.push_back(9 + (i % 3));
      add(8, 6); add(10, 1);
      run_case("R5", 0);
    end

    // R6: a frame-like sequence with nibble separators; last run held back
    bp_mode = 2;
    cyc_q.delete();
    add(8, 12); add(10, 10); add(8, 7); add(10, 5); add(8, 6); add(10, 5);
    add(8, 13); add(10, 10);
    run_case("R6", 0);

    // R3: 260-sample interval counts as long tone
    bp_mode = 0;
    cyc_q.delete();
    add(8, 6); add(260, 1); add(10, 4); add(8, 6); add(10, 1);
    run_case("R3", 0);

    // R7: run of 260 cycles must not wrap
    bp_mode = 1;
    cyc_q.delete();
    add(10, 5); add(8, 260); add(10, 5); add(8, 1);
    run_case("R7", 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule